// File: doc/BRIEF.md
# Serial Modem Mode Controller

This block decides whether a serial modem's host link is in command mode or in data-transfer mode. It watches the host's active-low terminal-ready and request-to-send lines, an escape input and a request to enter data mode. From these it drives the current mode, an active-low clear-to-send line and a qualifier that tells the command parser when it may take characters. All timing is counted in ticks of a prescaled millisecond strobe that comes from outside the block.

The rules for leaving data mode differ by cause. If terminal-ready is released, the block waits a fixed number of ticks before it falls back to command mode. A rising edge on the escape input acts on the next clock. If request-to-send is released, the block waits a programmable number of ticks; a value of zero disables this wait. When that wait expires, the block also raises clear-to-send. Each cause has its own enable, except the request-to-send wait, which is disabled by its zero value. All inputs are taken to be synchronous to `clk`.

Top module: `modem_mode_ctrl`

## Requirements
- R1: While `rst` is high, at the next clock edge the block is in command mode (`mode_data`=0) with `cts_n`=1, so `cmd_ok`=0.
- R2: In command mode, if `data_req`=1, `rts_n`=0 and `cts_n`=0 at a clock edge, `mode_data` becomes 1 after that edge. If any of these three conditions is not met, the block stays in command mode.
- R3: In data mode with `opt_dtr_en`=1, each edge with `dtr_n`=1 and `ms_tick`=1 counts one tick. The edge that samples the DTR_MS-th consecutive counted tick (default 100) returns the block to command mode.
- R4: The terminal-ready count restarts from zero whenever `dtr_n` is sampled low or `opt_dtr_en` is 0. With `opt_dtr_en`=0, `dtr_n` has no effect on the mode.
- R5: In command mode, `dtr_n` has no effect on `mode_data`, `cts_n` or `cmd_ok`.
- R6: In data mode with `opt_esc_en`=1, a clock edge at which `esc`=1 and `esc` was 0 at the previous edge returns the block to command mode. `esc` held high causes no further action. With `opt_esc_en`=0, `esc` has no effect.
- R7: In data mode with `rts_limit`=N>0, the edge that samples the N-th consecutive tick with `rts_n`=1 returns the block to command mode and sets `cts_n`=1 at that same edge. Before that edge, `cts_n` stays 0.
- R8: With `rts_limit`=0, `rts_n`=1 never ends data mode, and `cts_n` stays 0 throughout data mode.
- R9: The request-to-send count restarts from zero whenever `rts_n` is sampled low in data mode.
- R10: In command mode, `cts_n` takes the value `rts_n` had at the previous clock edge.
- R11: `cmd_ok`=1 exactly when the block is in command mode with `cts_n`=0 and `rts_n`=0, whatever the value of `dtr_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| dtr_n | input | 1 | Terminal ready from host, active low |
| rts_n | input | 1 | Request to send from host, active low |
| esc | input | 1 | Escape request; rising edge acts |
| data_req | input | 1 | Request to enter data mode |
| rts_limit | input | TW (8) | Request-to-send wait in ticks, 0 disables |
| opt_dtr_en | input | 1 | Enables the terminal-ready exit |
| opt_esc_en | input | 1 | Enables the escape exit |
| mode_data | output | 1 | 1 in data mode, 0 in command mode |
| cts_n | output | 1 | Clear to send to host, active low |
| cmd_ok | output | 1 | Command characters may be accepted |

## Verification
Directed runs pin down the exact tick on which each exit fires: 99 against 100 ticks for terminal-ready, and 4 against 5 for a request-to-send wait of five. These runs show whether the counting is off by one. Interrupted releases of both lines show whether a count restarts or only pauses. Escape is held high and then pulsed with its enable off, which shows a level-triggered or ungated escape. Random stimulus then mixes sparse ticks, sticky line releases, escape pulses and several wait limits, including zero. A bench model checks all three outputs every cycle, which exposes wrong priorities between exits that happen together and the wrong clear-to-send value on each kind of exit.

// File: rtl/mmc_pkg.sv
package mmc_pkg;

  typedef enum logic {
    MODE_CMD  = 1'b0,
    MODE_DATA = 1'b1
  } link_mode_e;

  // A counter of W bits reaches its limit on the tick that would make it equal
  // to the limit; limit zero never reaches.
  function automatic logic limit_hit(input logic [15:0] count, input logic [15:0] limit);
    return (limit != 16'd0) && (count == limit - 16'd1);
  endfunction

endpackage

// File: rtl/mmc_rise.sv
module mmc_rise (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign rise = level & ~prev_q;
endmodule

// File: rtl/mmc_tick_timer.sv
module mmc_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         fire
);
  import mmc_pkg::*;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  assign fire = run & tick & limit_hit(16'(cnt_q), 16'(limit));

  // R4 R9: a stopped timer starts over from zero
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));

  // R8: a zero limit never expires
  zero_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (limit == '0) |-> !fire);
endmodule

// File: rtl/mmc_mode_fsm.sv
module mmc_mode_fsm (
  input  logic clk,
  input  logic rst,
  input  logic data_req,
  input  logic rts_n,
  input  logic dtr_exit,
  input  logic esc_exit,
  input  logic rts_exit,
  output logic mode_data,
  output logic cts_n
);
  import mmc_pkg::*;

  link_mode_e mode_q, mode_nx;
  logic       cts_q, cts_nx;

  always_comb begin
    mode_nx = mode_q;
    cts_nx  = cts_q;
    if (mode_q == MODE_DATA) begin
      cts_nx = rts_exit;
      if (dtr_exit || esc_exit || rts_exit) mode_nx = MODE_CMD;
    end else begin
      cts_nx = rts_n;
      if (data_req && !rts_n && !cts_q) mode_nx = MODE_DATA;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_CMD;
      cts_q  <= 1'b1;
    end else begin
      mode_q <= mode_nx;
      cts_q  <= cts_nx;
    end
  end

  assign mode_data = (mode_q == MODE_DATA);
  assign cts_n     = cts_q;

  // R2
  entry_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_data && data_req && !rts_n && !cts_n) |=> mode_data);

  // R7
  rts_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_data && rts_exit) |=> (!mode_data && cts_n));

  // R8
  data_cts_low_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_data && !rts_exit) |=> !cts_n);

  // R10
  cmd_cts_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_data |=> (cts_n == $past(rts_n)));

  // R6
  esc_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_data && esc_exit) |=> !mode_data);
endmodule

// File: rtl/modem_mode_ctrl.sv
module modem_mode_ctrl #(
  parameter int TW     = 8,
  parameter int DTR_MS = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ms_tick,
  input  logic          dtr_n,
  input  logic          rts_n,
  input  logic          esc,
  input  logic          data_req,
  input  logic [TW-1:0] rts_limit,
  input  logic          opt_dtr_en,
  input  logic          opt_esc_en,
  output logic          mode_data,
  output logic          cts_n,
  output logic          cmd_ok
);
  localparam int DW = $clog2(DTR_MS + 1);
  localparam logic [DW-1:0] DTR_LIMIT = DW'(DTR_MS);

  logic esc_rise;
  logic dtr_run, rts_run;
  logic dtr_exit, rts_exit, esc_exit;

  mmc_rise u_esc_edge (
    .clk   (clk),
    .rst   (rst),
    .level (esc),
    .rise  (esc_rise)
  );

  assign dtr_run  = mode_data & opt_dtr_en & dtr_n;
  assign rts_run  = mode_data & rts_n;
  assign esc_exit = mode_data & opt_esc_en & esc_rise;

  mmc_tick_timer #(.W(DW)) u_dtr_timer (
    .clk   (clk),
    .rst   (rst),
    .run   (dtr_run),
    .tick  (ms_tick),
    .limit (DTR_LIMIT),
    .fire  (dtr_exit)
  );

  mmc_tick_timer #(.W(TW)) u_rts_timer (
    .clk   (clk),
    .rst   (rst),
    .run   (rts_run),
    .tick  (ms_tick),
    .limit (rts_limit),
    .fire  (rts_exit)
  );

  mmc_mode_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .data_req  (data_req),
    .rts_n     (rts_n),
    .dtr_exit  (dtr_exit),
    .esc_exit  (esc_exit),
    .rts_exit  (rts_exit),
    .mode_data (mode_data),
    .cts_n     (cts_n)
  );

  assign cmd_ok = ~mode_data & ~cts_n & ~rts_n;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!mode_data && cts_n && !cmd_ok));

  // R5: the terminal-ready timer cannot fire outside data mode
  dtr_cmd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_data |-> !dtr_exit);

  // R3
  dtr_exit_chk: assert property (@(posedge clk) disable iff (rst)
    dtr_exit |=> !mode_data);

  // R4
  dtr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!opt_dtr_en || !dtr_n) |-> !dtr_exit);
endmodule

// File: tb/modem_mode_ctrl_test.sv
module modem_mode_ctrl_test;
  localparam int DTR_MS = 100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ms_tick = 1'b0, dtr_n = 1'b1, rts_n = 1'b1, esc = 1'b0, data_req = 1'b0;
  logic [7:0] rts_limit = 8'd0;
  logic       opt_dtr_en = 1'b0, opt_esc_en = 1'b0;
  logic       mode_data, cts_n, cmd_ok;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5ns clk = ~clk;

  modem_mode_ctrl uut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .dtr_n(dtr_n), .rts_n(rts_n),
    .esc(esc), .data_req(data_req), .rts_limit(rts_limit),
    .opt_dtr_en(opt_dtr_en), .opt_esc_en(opt_esc_en),
    .mode_data(mode_data), .cts_n(cts_n), .cmd_ok(cmd_ok)
  );

  // Reference model built from the requirements
  bit m_data, m_cts, m_esc_prev;
  int m_dticks, m_rticks;

  function automatic bit ok_expected(bit data, bit cts, bit rts);
    return !data && !cts && !rts;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_data = 0; m_cts = 1; m_esc_prev = 0; m_dticks = 0; m_rticks = 0;
    end else begin
      bit d_on, r_on, d_done, r_done, e_done;
      d_on   = m_data && opt_dtr_en && dtr_n;
      r_on   = m_data && rts_n;
      d_done = d_on && ms_tick && (m_dticks + 1 == DTR_MS);
      r_done = r_on && ms_tick && (rts_limit != 0) && (m_rticks + 1 == int'(rts_limit));
      e_done = m_data && opt_esc_en && esc && !m_esc_prev;
      m_dticks = d_on ? m_dticks + int'(ms_tick) : 0;
      m_rticks = r_on ? m_rticks + int'(ms_tick) : 0;
      m_esc_prev = esc;
      if (m_data) begin
        m_cts = r_done;
        if (d_done || r_done || e_done) m_data = 0;
      end else begin
        if (data_req && !rts_n && !m_cts) m_data = 1;
        m_cts = rts_n;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_out(input string req, input bit e_mode, input bit e_cts);
    chk(mode_data == e_mode, req, "mode_data", int'(mode_data), int'(e_mode));
    chk(cts_n == e_cts, req, "cts_n", int'(cts_n), int'(e_cts));
  endtask

  // one clock: inputs already set at a falling edge, sample at the next one
  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic enter_data();
    dtr_n = 0; rts_n = 0; data_req = 0; cyc(2);
    data_req = 1; cyc(1); data_req = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5ns);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    cyc(3);
    // R1
    expect_out("R1", 0, 1);
    chk(cmd_ok == 0, "R1", "cmd_ok", int'(cmd_ok), 0);
    rst = 0; ms_tick = 1;

    // R2: request while rts_n high does nothing
    data_req = 1; cyc(1);
    chk(mode_data == 0, "R2", "no entry with rts high", int'(mode_data), 0);
    data_req = 0;
    // R10
    rts_n = 0; cyc(1);
    chk(cts_n == 0, "R10", "cts follows rts", int'(cts_n), 0);
    // R11 R5
    dtr_n = 1; cyc(1);
    chk(cmd_ok == 1, "R11", "cmd_ok with dtr high", int'(cmd_ok), 1);
    expect_out("R5", 0, 0);
    dtr_n = 0; data_req = 1; cyc(1); data_req = 0;
    chk(mode_data == 1, "R2", "entry", int'(mode_data), 1);
    chk(cmd_ok == 0, "R11", "cmd_ok in data mode", int'(cmd_ok), 0);

    // R3
    opt_dtr_en = 1; dtr_n = 1; cyc(DTR_MS - 1);
    chk(mode_data == 1, "R3", "before last tick", int'(mode_data), 1);
    cyc(1);
    expect_out("R3", 0, 0);

    // R4: interrupted release restarts the count
    enter_data();
    dtr_n = 1; cyc(50); dtr_n = 0; cyc(1);
    dtr_n = 1; cyc(DTR_MS - 1);
    chk(mode_data == 1, "R4", "count restarted", int'(mode_data), 1);
    dtr_n = 0; opt_dtr_en = 0; cyc(1);
    dtr_n = 1; cyc(DTR_MS + 50);
    chk(mode_data == 1, "R4", "option off", int'(mode_data), 1);
    dtr_n = 0;

    // R6
    opt_esc_en = 1; esc = 1; cyc(1);
    expect_out("R6", 0, 0);
    enter_data(); cyc(5);
    chk(mode_data == 1, "R6", "held escape", int'(mode_data), 1);
    esc = 0; opt_esc_en = 0; cyc(1); esc = 1; cyc(1); esc = 0; cyc(1);
    chk(mode_data == 1, "R6", "escape disabled", int'(mode_data), 1);

    // R7
    rts_limit = 8'd5; rts_n = 1; cyc(4);
    expect_out("R7", 1, 0);
    cyc(1);
    expect_out("R7", 0, 1);
    chk(cmd_ok == 0, "R11", "cmd_ok with cts high", int'(cmd_ok), 0);

    // R9
    enter_data();
    rts_n = 1; cyc(3); rts_n = 0; cyc(1); rts_n = 1; cyc(4);
    expect_out("R9", 1, 0);
    cyc(1);
    expect_out("R9", 0, 1);

    // R8
    rts_limit = 8'd0; enter_data();
    rts_n = 1; cyc(300);
    expect_out("R8", 1, 0);
    rts_n = 0; cyc(1);

    // Random phase against the model
    void'($urandom(32'h5eed_1234));
    for (int seg = 0; seg < 8; seg++) begin
      rts_n = 0; cyc(1);
      rts_limit  = 8'($urandom_range(0, 9));
      opt_dtr_en = 1'($urandom_range(0, 1));
      opt_esc_en = 1'($urandom_range(0, 1));
      for (int i = 0; i < 2500; i++) begin
        ms_tick  = ($urandom_range(0, 2) == 0);
        if ($urandom_range(0, 63) == 0) dtr_n = ~dtr_n;
        if ($urandom_range(0, 15) == 0) rts_n = ~rts_n;
        esc      = ($urandom_range(0, 40) == 0);
        data_req = ($urandom_range(0, 3) == 0);
        cyc(1);
        chk(mode_data == m_data, "R2", "random mode", int'(mode_data), int'(m_data));
        chk(cts_n == m_cts, "R10", "random cts_n", int'(cts_n), int'(m_cts));
        chk(cmd_ok == ok_expected(m_data, m_cts, rts_n), "R11", "random cmd_ok",
            int'(cmd_ok), int'(ok_expected(m_data, m_cts, rts_n)));
      end
    end

    done = 1'b1;
    finish_run();
  end
endmodule